// File: doc/BRIEF.md
# Full-Period Pseudorandom Address Sequencer

This block produces a scrambled sequence of memory addresses that covers every one of the 2^n values of an n-bit address exactly once per period, zero included. A conventional maximal-length shift register with XOR feedback skips the all-zero value and stalls if it ever lands there. This sequencer corrects the feedback so that zero is spliced into the cycle, giving a period of exactly 2^n.

The address width n is chosen at run time, from 2 to 16 bits, through a length code that is captured when a seed is loaded. Each advance pulse steps the sequence once. A one-cycle wrap pulse marks the point where the sequence comes back to the loaded seed after a complete period, so a controller reading memory in this order knows when every location has been visited.

Top module: `fullper_addr_seq`

## Requirements
- R1: While rst_ni is low and after its release, addr_o is 0 and wrap_o is 0; the captured length is 16 bits.
- R2: When seed_load_i is high at a rising clock edge, addr_o after that edge equals seed_i with all bits at and above the selected width cleared. The width is len_sel_i + 2, and code 15 selects 16 bits. A load takes priority over adv_i in the same cycle.
- R3: When adv_i is high and seed_load_i is low at a rising edge, the state s of width n becomes {s[n-2:0], f}, where f is the XOR of the bits of s under the tap mask for n, inverted when s[n-2:0] is all zero. Tap masks (hex): n=2:3, 3:6, 4:C, 5:14, 6:30, 7:60, 8:B8, 9:110, 10:240, 11:500, 12:829, 13:100D, 14:2015, 15:6000, 16:D008.
- R4: From any seed, 2^n consecutive advances visit each n-bit value exactly once and end back at the seed.
- R5: The state with only bit n-1 set advances to 0, and the state 0 advances to 1.
- R6: Bits of addr_o at and above the captured width are always 0.
- R7: wrap_o is high for exactly one cycle, in the cycle that follows the 2^n-th advance after the most recent seed load, when addr_o again equals the seed; it is low at all other times, and a seed load restarts the advance count.
- R8: With adv_i and seed_load_i both low, addr_o and wrap_o-relevant progress hold (addr_o unchanged).
- R9: A change of len_sel_i without a seed load has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_sel_i | input | 4 | Length code, width = code + 2 (15 gives 16) |
| seed_load_i | input | 1 | Load seed and capture length |
| seed_i | input | 16 | Seed value |
| adv_i | input | 1 | Step the sequence once |
| addr_o | output | 16 | Current address |
| wrap_o | output | 1 | One-cycle full-period marker |

## Verification
Every result of this block is registered once, so addr_o and wrap_o reflect a load or an advance one clock edge after the cycle in which the control input was high. The bench drives inputs just after a falling edge and reads the outputs at the following falling edge, halfway between the capturing edge and the next one. For full-period runs, adv_i stays high and each falling edge is checked against the count of advances made so far, so the wrap pulse is expected exactly at the 2^n-th sample and nowhere else.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int unsigned TAB_W = 16;
  localparam int unsigned MIN_LEN = 2;

  // maximal-length tap masks, bit k = stage k
  function automatic logic [TAB_W-1:0] tap_mask(input int unsigned n);
    case (n)
      2:       return 16'h0003;
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      13:      return 16'h100D;
      14:      return 16'h2015;
      15:      return 16'h6000;
      default: return 16'hD008;
    endcase
  endfunction
endpackage

// File: rtl/fpas_len_decode.sv
module fpas_len_decode #(
  parameter int unsigned MAX_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [MAX_W-1:0]  taps_o,
  output logic [MAX_W-1:0]  wmask_o,
  output logic [MAX_W-1:0]  lmask_o
);
  import fpas_pkg::*;
  localparam int unsigned TOP_CODE = MAX_W - MIN_LEN;

  int unsigned n_w;
  logic [TAB_W-1:0] full_taps;

  always_comb begin
    if (int'(code_i) > TOP_CODE) n_w = MAX_W;
    else                         n_w = int'(code_i) + MIN_LEN;
    full_taps = tap_mask(n_w);
  end

  assign taps_o = full_taps[MAX_W-1:0];

  for (genvar i = 0; i < MAX_W; i++) begin : g_mask
    assign wmask_o[i] = (n_w > i);
    // all stages below the output stage
    assign lmask_o[i] = (n_w > i + 1);
  end
endmodule

// File: rtl/fpas_next_state.sv
module fpas_next_state #(
  parameter int unsigned MAX_W = 16
) (
  input  logic [MAX_W-1:0] state_i,
  input  logic [MAX_W-1:0] taps_i,
  input  logic [MAX_W-1:0] wmask_i,
  input  logic [MAX_W-1:0] lmask_i,
  output logic [MAX_W-1:0] next_o
);
  logic lin_fb;
  logic low_zero;
  logic fb;

  assign lin_fb   = ^(state_i & taps_i);
  // splice zero into the cycle: 100..0 -> 0, 0 -> 1
  assign low_zero = ~|(state_i & lmask_i);
  assign fb       = lin_fb ^ low_zero;
  assign next_o   = {state_i[MAX_W-2:0], fb} & wmask_i;
endmodule

// File: rtl/fpas_period_ctr.sv
module fpas_period_ctr #(
  parameter int unsigned MAX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [MAX_W-1:0] wmask_i,
  output logic             wrap_o
);
  logic [MAX_W-1:0] cnt_q;
  logic             wrap_q;
  logic             last;

  assign last = (cnt_q == wmask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (adv_i) begin
      cnt_q  <= last ? '0 : cnt_q + 1'b1;
      wrap_q <= last;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign wrap_o = wrap_q;

  // R7
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> !wrap_q);
  // R7
  wrap_after_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrap_q) |-> $past(adv_i) && !$past(clear_i));
  // R7
  clear_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0 && !wrap_q);
endmodule

// File: rtl/fullper_addr_seq.sv
module fullper_addr_seq #(
  parameter int unsigned MAX_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] len_sel_i,
  input  logic              seed_load_i,
  input  logic [MAX_W-1:0]  seed_i,
  input  logic              adv_i,
  output logic [MAX_W-1:0]  addr_o,
  output logic              wrap_o
);
  import fpas_pkg::*;
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(MAX_W - MIN_LEN);

  logic [CODE_W-1:0] code_q;
  logic [MAX_W-1:0]  state_q;
  logic [MAX_W-1:0]  cur_taps, cur_wmask, cur_lmask;
  logic [MAX_W-1:0]  ld_taps, ld_wmask, ld_lmask;
  logic [MAX_W-1:0]  next_state;
  logic              step;

  fpas_len_decode #(.MAX_W(MAX_W), .CODE_W(CODE_W)) cur_dec_i (
    .code_i (code_q),
    .taps_o (cur_taps),
    .wmask_o(cur_wmask),
    .lmask_o(cur_lmask)
  );

  fpas_len_decode #(.MAX_W(MAX_W), .CODE_W(CODE_W)) ld_dec_i (
    .code_i (len_sel_i),
    .taps_o (ld_taps),
    .wmask_o(ld_wmask),
    .lmask_o(ld_lmask)
  );

  fpas_next_state #(.MAX_W(MAX_W)) nxt_i (
    .state_i(state_q),
    .taps_i (cur_taps),
    .wmask_i(cur_wmask),
    .lmask_i(cur_lmask),
    .next_o (next_state)
  );

  assign step = adv_i & ~seed_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= RST_CODE;
      state_q <= '0;
    end else if (seed_load_i) begin
      code_q  <= len_sel_i;
      state_q <= seed_i & ld_wmask;
    end else if (adv_i) begin
      state_q <= next_state;
    end
  end

  fpas_period_ctr #(.MAX_W(MAX_W)) ctr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(seed_load_i),
    .adv_i  (step),
    .wmask_i(cur_wmask),
    .wrap_o (wrap_o)
  );

  assign addr_o = state_q;

  // R6
  width_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q & ~cur_wmask) == '0);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !seed_load_i |=> $stable(state_q));
  // R5
  zero_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && state_q == '0 |=> state_q == MAX_W'(1));
  // R5
  zero_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && state_q != '0 && (state_q & cur_lmask) == '0 |=> state_q == '0);
  // R2
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> state_q == ($past(seed_i) & cur_wmask));
  // R9
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_load_i |=> $stable(code_q));
endmodule

// File: tb/fullper_addr_seq_tb_top.sv
module fullper_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  len_sel = 4'd0;
  logic        load = 1'b0;
  logic [15:0] seed = '0;
  logic        adv = 1'b0;
  logic [15:0] addr;
  logic        wrap;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fullper_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .len_sel_i(len_sel), .seed_load_i(load),
    .seed_i(seed), .adv_i(adv), .addr_o(addr), .wrap_o(wrap)
  );

  // {len code, seed in, expected after load, expected after one advance}
  localparam logic [51:0] VEC [12] = '{
    {4'd0,  16'h0002, 16'h0002, 16'h0000},
    {4'd0,  16'h0000, 16'h0000, 16'h0001},
    {4'd1,  16'h0005, 16'h0005, 16'h0003},
    {4'd2,  16'h0009, 16'h0009, 16'h0003},
    {4'd3,  16'h001F, 16'h001F, 16'h001E},
    {4'd6,  16'h0080, 16'h0080, 16'h0000},
    {4'd6,  16'h00FF, 16'h00FF, 16'h00FE},
    {4'd8,  16'hFFFF, 16'h03FF, 16'h03FE},
    {4'd10, 16'h0FFF, 16'h0FFF, 16'h0FFE},
    {4'd11, 16'h1000, 16'h1000, 16'h0000},
    {4'd14, 16'h0001, 16'h0001, 16'h0002},
    {4'd15, 16'hFFFF, 16'hFFFF, 16'hFFFE}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] code, input logic [15:0] s);
    @(negedge clk);
    len_sel = code; seed = s; load = 1'b1; adv = 1'b0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_adv();
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] seq2 [4] = '{16'h1, 16'h3, 16'h2, 16'h0};
    logic [15:0] seq3 [8] = '{16'h1, 16'h2, 16'h5, 16'h3, 16'h7, 16'h6, 16'h4, 16'h0};
    bit seen [4096];
    int dups, wraps, bad_wrap;

    // R1 reset state
    #5;
    chk(addr, 16'h0, "R1 addr in reset");
    chk({15'd0, wrap}, 16'h0, "R1 wrap in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(addr, 16'h0, "R1 addr after reset");
    do_adv();  // 16-bit default: 0 -> 1
    chk(addr, 16'h1, "R1 default width 16, R5 zero exit");
    do_adv();
    chk(addr, 16'h2, "R1 default width 16 step");

    // R2 R3 R5 R6 vector walk
    foreach (VEC[i]) begin
      do_load(VEC[i][51:48], VEC[i][47:32]);
      chk(addr, VEC[i][31:16], $sformatf("R2 R6 load vec %0d", i));
      do_adv();
      chk(addr, VEC[i][15:0], $sformatf("R3 R5 advance vec %0d", i));
    end

    // R4 R7 exact 2-bit and 3-bit periods
    do_load(4'd0, 16'h0000);
    adv = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(addr, seq2[k], "R4 2-bit sequence");
      chk({15'd0, wrap}, (k == 3) ? 16'h1 : 16'h0, "R7 2-bit wrap");
    end
    adv = 1'b0;
    do_load(4'd1, 16'h0000);
    adv = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(addr, seq3[k], "R4 3-bit sequence");
      chk({15'd0, wrap}, (k == 7) ? 16'h1 : 16'h0, "R7 3-bit wrap");
    end
    adv = 1'b0;
    @(negedge clk);
    chk({15'd0, wrap}, 16'h0, "R7 wrap one cycle only");

    // R8 hold with adv low
    do_load(4'd1, 16'h0005);
    repeat (3) @(negedge clk);
    chk(addr, 16'h0005, "R8 hold");

    // R9 length change without load ignored (stays 3-bit)
    len_sel = 4'd14;
    do_adv();
    chk(addr, 16'h0003, "R9 len_sel ignored step1");
    do_adv();
    chk(addr, 16'h0007, "R9 len_sel ignored step2");

    // R2 load wins over advance
    @(negedge clk);
    len_sel = 4'd1; seed = 16'h0002; load = 1'b1; adv = 1'b1;
    @(negedge clk);
    load = 1'b0; adv = 1'b0;
    chk(addr, 16'h0002, "R2 load priority");

    // R7 reload restarts count: 3 advances, reload, then 8 more
    do_adv(); do_adv(); do_adv();
    do_load(4'd1, 16'h0002);
    adv = 1'b1;
    bad_wrap = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (wrap !== (k == 7)) bad_wrap++;
    end
    adv = 1'b0;
    chk(bad_wrap[15:0], 16'h0, "R7 reload restarts count");
    chk(addr, 16'h0002, "R7 back to seed");

    // R4 R7 12-bit full period coverage
    do_load(4'd10, 16'h05A5);
    dups = 0; wraps = 0; bad_wrap = 0;
    adv = 1'b1;
    for (int k = 0; k < 4096; k++) begin
      @(negedge clk);
      if (seen[addr[11:0]]) dups++;
      seen[addr[11:0]] = 1'b1;
      if (addr[15:12] != 4'd0) dups++;
      if (wrap) begin
        wraps++;
        if (k != 4095) bad_wrap++;
      end
    end
    adv = 1'b0;
    chk(dups[15:0], 16'h0, "R4 R6 12-bit all values once");
    chk(wraps[15:0], 16'h1, "R7 12-bit wrap count");
    chk(bad_wrap[15:0], 16'h0, "R7 12-bit wrap position");
    chk(addr, 16'h05A5, "R4 12-bit returns to seed");

    finish_run();
  end
endmodule